// File: doc/BRIEF.md
# Nibble-Loaded Bank Register Mapper

This block is the first of several address-mapping personalities in a cartridge mapper. It watches CPU writes to the upper half of the address space and keeps a small set of bank registers: two switchable PRG banks, eight CHR banks loaded four bits at a time, and a one-bit mirroring control. From these it drives an 8 KB PRG bank number for each of the four CPU windows between 0x8000 and 0xFFFF. It also drives a 1 KB CHR bank number for each of the eight PPU windows and a nametable mirroring bit.

A CHR bank register is filled by two writes. Address bit 0 selects the half to replace, and a handful of address bits (A13, A12, and A11 merged with A1) select the register. This means several addresses alias onto each register. An external mode value contributes one extra high CHR bank bit. The enclosing mapper asserts an enable input only while this personality is the active one. All bank outputs follow the registers combinationally.

Top module: `nibmap_top`

## Requirements
- R1: After reset, PRG registers 0 and 1 hold 0x00 and 0x01. CHR registers 0 to 3 hold 0xFF and CHR registers 4 to 7 hold 0x04 to 0x07. The mirroring register holds 0, so `mirror_o` reads 1.
- R2: A write whose full address lies in 0xB000..0xE003 targets CHR register ((({A13,A12,A11|A1}) + 2) mod 8). With A0 = 0, data bits 3:0 replace bits 3:0 of that register and bits 7:4 are kept.
- R3: In the same range, with A0 = 1, data bits 3:0 replace bits 7:4 of the register and bits 3:0 are kept.
- R4: A write to 0x8000..0x8FFF loads the full data byte into PRG register 0. A write to 0xA000..0xAFFF loads it into PRG register 1. `prg_bank_o[0]` and `prg_bank_o[1]` show these registers.
- R5: A write to 0x9000..0x9FFF loads data bit 0 into the mirroring register. `mirror_o` is the inverse of that bit and changes only after such a write.
- R6: `prg_bank_o[2]` is always 0xFE and `prg_bank_o[3]` is always 0xFF.
- R7: Each `chr_bank_o[k]` is 9 bits wide. Bits 7:0 are CHR register k and bit 8 equals `mode_i[2]`, tracking the input without a clock.
- R8: A write takes effect only on a clock edge where both `wr_i` and `en_i` are high. Otherwise all registers hold.
- R9: Enabled writes to addresses outside the three PRG/mirroring ranges and the CHR range leave every register unchanged. Examples are below 0x8000, 0xE004..0xEFFF and 0xF000..0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | CPU write strobe |
| en_i | input | 1 | High while this personality is active |
| addr_i | input | 16 | CPU write address |
| data_i | input | 8 | CPU write data |
| mode_i | input | 8 | External mode value; bit 2 is the high CHR bit |
| prg_bank_o | output | 4x8 | 8 KB bank for windows 0x8000, 0xA000, 0xC000, 0xE000 |
| chr_bank_o | output | 8x9 | 1 KB CHR bank for each of the eight PPU windows |
| mirror_o | output | 1 | Mirroring select |

## Verification
The CHR decode is driven in three ways. The first is one low-half write to the canonical address of every register, which shows that each register is separately addressable. The second is a high-half write to the same set, which shows that the two halves merge rather than overwrite. The third uses aliased addresses with A11, A10 and A1 set, which separates a correct index decode from one that ignores A11 or A1 or keeps A10. PRG and mirroring loads are driven at both ends of their 4 KB ranges. Writes just past 0xE003, in 0xF000 and below 0x8000, and with the enable low, must leave every output as it was. Toggling `mode_i` bit 2 against its neighbours shows that only that bit reaches the CHR outputs.

// File: rtl/nibmap_pkg.sv
package nibmap_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PRG0,
        OP_PRG1,
        OP_MIRR,
        OP_CHR_LO,
        OP_CHR_HI
    } nib_op_e;

    localparam logic [15:0] CHR_FIRST = 16'hB000;
    localparam logic [15:0] CHR_LAST  = 16'hE003;
    localparam int          CHR_BIAS  = 2;
    localparam int          FIXED_LOW_RESET_N = 4;

endpackage

// File: rtl/nibmap_decode.sv
module nibmap_decode
    import nibmap_pkg::*;
#(
    parameter int AW   = 16,
    parameter int IDXW = 3
) (
    input  logic            wr_i,
    input  logic            en_i,
    input  logic [AW-1:0]   addr_i,
    output nib_op_e         op_o,
    output logic [IDXW-1:0] idx_o
);

    logic [3:0] page;
    logic       in_chr;

    assign page   = addr_i[AW-1 -: 4];
    assign in_chr = (addr_i >= CHR_FIRST) && (addr_i <= CHR_LAST);

    // register index: A13, A12 and (A11 or A1), rotated by the bias
    assign idx_o = {addr_i[13], addr_i[12], addr_i[11] | addr_i[1]} + IDXW'(CHR_BIAS);

    always_comb begin
        op_o = OP_NONE;
        if (wr_i && en_i) begin
            if (in_chr) begin
                op_o = addr_i[0] ? OP_CHR_HI : OP_CHR_LO;
            end else begin
                case (page)
                    4'h8:    op_o = OP_PRG0;
                    4'h9:    op_o = OP_MIRR;
                    4'hA:    op_o = OP_PRG1;
                    default: op_o = OP_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/nibmap_regs.sv
module nibmap_regs
    import nibmap_pkg::*;
#(
    parameter int DW    = 8,
    parameter int PRG_N = 2,
    parameter int CHR_N = 8,
    parameter int CHR_W = 8,
    parameter int IDXW  = $clog2(CHR_N)
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  nib_op_e                      op_i,
    input  logic [IDXW-1:0]              idx_i,
    input  logic [DW-1:0]                data_i,
    output logic [PRG_N-1:0][DW-1:0]     prg_o,
    output logic [CHR_N-1:0][CHR_W-1:0]  chr_o,
    output logic                         mirr_o
);

    localparam int HALF = CHR_W / 2;

    typedef struct packed {
        logic [PRG_N-1:0][DW-1:0]    prg;
        logic [CHR_N-1:0][CHR_W-1:0] chr;
        logic                        mirr;
    } bank_state_t;

    bank_state_t state_d, state_q;

    function automatic bank_state_t reset_state();
        bank_state_t s;
        for (int p = 0; p < PRG_N; p++) s.prg[p] = DW'(p);
        for (int c = 0; c < CHR_N; c++)
            s.chr[c] = (c < FIXED_LOW_RESET_N) ? {CHR_W{1'b1}} : CHR_W'(c);
        s.mirr = 1'b0;
        return s;
    endfunction

    always_comb begin
        state_d = state_q;
        case (op_i)
            OP_PRG0:   state_d.prg[0] = data_i;
            OP_PRG1:   state_d.prg[1] = data_i;
            OP_MIRR:   state_d.mirr   = data_i[0];
            OP_CHR_LO: state_d.chr[idx_i][HALF-1:0]     = data_i[HALF-1:0];
            OP_CHR_HI: state_d.chr[idx_i][CHR_W-1:HALF] = data_i[HALF-1:0];
            default:   ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= reset_state();
        else         state_q <= state_d;
    end

    assign prg_o  = state_q.prg;
    assign chr_o  = state_q.chr;
    assign mirr_o = state_q.mirr;

    a_r1_reset_values: assert property (@(posedge clk_i)
        !rst_ni |=> (state_q.prg[1] == DW'(1)) && (state_q.chr[0] == {CHR_W{1'b1}})
                    && (state_q.chr[CHR_N-1] == CHR_W'(CHR_N-1)) && !state_q.mirr);

    a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_NONE) |=> $stable(state_q));

    a_r4_prg0_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_PRG0) |=> (state_q.prg[0] == $past(data_i)));

    a_r3_hi_keeps_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_CHR_HI) |=>
            (state_q.chr[$past(idx_i)][HALF-1:0] == $past(state_q.chr[idx_i][HALF-1:0])));

    a_r2_lo_keeps_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_CHR_LO) |=>
            (state_q.chr[$past(idx_i)][CHR_W-1:HALF] == $past(state_q.chr[idx_i][CHR_W-1:HALF])));

endmodule

// File: rtl/nibmap_window.sv
module nibmap_window #(
    parameter int DW     = 8,
    parameter int PRG_N  = 2,
    parameter int WIN_N  = 4,
    parameter int CHR_N  = 8,
    parameter int CHR_W  = 8
) (
    input  logic [PRG_N-1:0][DW-1:0]      prg_i,
    input  logic [CHR_N-1:0][CHR_W-1:0]   chr_i,
    input  logic                          mirr_i,
    input  logic                          base_i,
    output logic [WIN_N-1:0][DW-1:0]      prg_bank_o,
    output logic [CHR_N-1:0][CHR_W:0]     chr_bank_o,
    output logic                          mirror_o
);

    localparam logic [DW-1:0] LAST_BANK   = {DW{1'b1}};
    localparam logic [DW-1:0] SECOND_LAST = {{(DW-1){1'b1}}, 1'b0};

    generate
        for (genvar w = 0; w < WIN_N; w++) begin : g_prg
            if (w < PRG_N) begin : g_switch
                assign prg_bank_o[w] = prg_i[w];
            end else if (w == WIN_N - 1) begin : g_last
                assign prg_bank_o[w] = LAST_BANK;
            end else begin : g_fixed
                assign prg_bank_o[w] = SECOND_LAST;
            end
        end
        for (genvar c = 0; c < CHR_N; c++) begin : g_chr
            assign chr_bank_o[c] = {base_i, chr_i[c]};
        end
    endgenerate

    assign mirror_o = ~mirr_i;

    a_r6_fixed_windows: assert property (@(prg_bank_o)
        (prg_bank_o[WIN_N-1] == LAST_BANK) && (prg_bank_o[WIN_N-2] == SECOND_LAST));

endmodule

// File: rtl/nibmap_top.sv
module nibmap_top
    import nibmap_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 8,
    parameter int WIN_N    = 4,
    parameter int CHR_N    = 8,
    parameter int CHR_W    = 8,
    parameter int MODE_BIT = 2
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       wr_i,
    input  logic                       en_i,
    input  logic [AW-1:0]              addr_i,
    input  logic [DW-1:0]              data_i,
    input  logic [7:0]                 mode_i,
    output logic [WIN_N-1:0][DW-1:0]   prg_bank_o,
    output logic [CHR_N-1:0][CHR_W:0]  chr_bank_o,
    output logic                       mirror_o
);

    localparam int PRG_N = 2;
    localparam int IDXW  = $clog2(CHR_N);

    nib_op_e                      op;
    logic [IDXW-1:0]              idx;
    logic [PRG_N-1:0][DW-1:0]     prg_regs;
    logic [CHR_N-1:0][CHR_W-1:0]  chr_regs;
    logic                         mirr_reg;

    nibmap_decode #(.AW(AW), .IDXW(IDXW)) u_decode (
        .wr_i   (wr_i),
        .en_i   (en_i),
        .addr_i (addr_i),
        .op_o   (op),
        .idx_o  (idx)
    );

    nibmap_regs #(.DW(DW), .PRG_N(PRG_N), .CHR_N(CHR_N), .CHR_W(CHR_W), .IDXW(IDXW)) u_regs (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .op_i   (op),
        .idx_i  (idx),
        .data_i (data_i),
        .prg_o  (prg_regs),
        .chr_o  (chr_regs),
        .mirr_o (mirr_reg)
    );

    nibmap_window #(.DW(DW), .PRG_N(PRG_N), .WIN_N(WIN_N), .CHR_N(CHR_N), .CHR_W(CHR_W)) u_window (
        .prg_i      (prg_regs),
        .chr_i      (chr_regs),
        .mirr_i     (mirr_reg),
        .base_i     (mode_i[MODE_BIT]),
        .prg_bank_o (prg_bank_o),
        .chr_bank_o (chr_bank_o),
        .mirror_o   (mirror_o)
    );

    a_r5_mirror_only_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(mirror_o) |-> $past(wr_i && en_i && (addr_i[AW-1 -: 4] == 4'h9)));

endmodule

// File: tb/nibmap_top_tb.sv
module nibmap_top_tb;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr = 1'b0;
    logic            en = 1'b0;
    logic [15:0]     addr = '0;
    logic [7:0]      data = '0;
    logic [7:0]      mode = '0;
    logic [3:0][7:0] prg_bank;
    logic [7:0][8:0] chr_bank;
    logic            mirror;

    int errors = 0;
    int checks = 0;

    logic [7:0] exp_prg0, exp_prg1;
    logic [7:0] exp_chr [8];
    logic       exp_mirr_reg;

    always #2 clk = ~clk;

    nibmap_top u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .wr_i       (wr),
        .en_i       (en),
        .addr_i     (addr),
        .data_i     (data),
        .mode_i     (mode),
        .prg_bank_o (prg_bank),
        .chr_bank_o (chr_bank),
        .mirror_o   (mirror)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write(input logic [15:0] a, input logic [7:0] d, input logic enable);
        @(negedge clk);
        addr = a; data = d; wr = 1'b1; en = enable;
        @(negedge clk);
        wr = 1'b0; en = 1'b0;
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R4 prg0"}, prg_bank[0], exp_prg0);
        chk({tag, " R4 prg1"}, prg_bank[1], exp_prg1);
        chk({tag, " R6 win2"}, prg_bank[2], 8'hFE);
        chk({tag, " R6 win3"}, prg_bank[3], 8'hFF);
        chk({tag, " R5 mirror"}, mirror, !exp_mirr_reg);
        for (int k = 0; k < 8; k++)
            chk($sformatf("%s R2/R3/R7 chr%0d", tag, k), chr_bank[k], {mode[2], exp_chr[k]});
    endtask

    task automatic t_reset();
        exp_prg0 = 8'h00; exp_prg1 = 8'h01; exp_mirr_reg = 1'b0;
        for (int k = 0; k < 8; k++) exp_chr[k] = (k < 4) ? 8'hFF : 8'(k);
        check_all("R1 reset");
    endtask

    task automatic t_chr_nibbles();
        logic [15:0] base_addr [8] = '{16'hB000, 16'hB002, 16'hC000, 16'hC002,
                                       16'hD000, 16'hD002, 16'hE000, 16'hE002};
        for (int k = 0; k < 8; k++) begin
            write(base_addr[k], 8'h50 | 8'(k), 1'b1);
            exp_chr[k] = {exp_chr[k][7:4], 4'(k)};
        end
        check_all("R2 low nibbles");
        for (int k = 0; k < 8; k++) begin
            write(base_addr[k] | 16'h0001, 8'hA0 | 8'(15 - k), 1'b1);
            exp_chr[k] = {4'(15 - k), exp_chr[k][3:0]};
        end
        check_all("R3 high nibbles");
    endtask

    task automatic t_chr_alias();
        write(16'hB802, 8'h09, 1'b1); exp_chr[1][3:0] = 4'h9;
        write(16'hBC03, 8'hF2, 1'b1); exp_chr[1][7:4] = 4'h2;
        write(16'hD400, 8'h0C, 1'b1); exp_chr[4][3:0] = 4'hC;
        write(16'hE003, 8'h0B, 1'b1); exp_chr[7][7:4] = 4'hB;
        check_all("R2 R3 alias");
    endtask

    task automatic t_prg();
        write(16'h8000, 8'h12, 1'b1);
        write(16'h8FFF, 8'h34, 1'b1); exp_prg0 = 8'h34;
        write(16'hA000, 8'h9A, 1'b1);
        write(16'hAFFF, 8'h56, 1'b1); exp_prg1 = 8'h56;
        check_all("R4 prg");
    endtask

    task automatic t_mirror();
        write(16'h9000, 8'h01, 1'b1); exp_mirr_reg = 1'b1;
        check_all("R5 mirror set");
        write(16'h9ABC, 8'hFE, 1'b1); exp_mirr_reg = 1'b0;
        check_all("R5 mirror clear");
    endtask

    task automatic t_mode();
        @(negedge clk); mode = 8'h04;
        #1 check_all("R7 mode bit set");
        mode = 8'hFB;
        #1 check_all("R7 mode bit clear");
        mode = 8'h00;
    endtask

    task automatic t_disabled();
        write(16'h8000, 8'hEE, 1'b0);
        write(16'h9000, 8'h01, 1'b0);
        write(16'hB000, 8'h0F, 1'b0);
        @(negedge clk);
        addr = 16'hA000; data = 8'h77; wr = 1'b0; en = 1'b1;
        @(negedge clk); en = 1'b0;
        check_all("R8 disabled");
    endtask

    task automatic t_outside();
        write(16'hE004, 8'h0F, 1'b1);
        write(16'hEFFF, 8'h0F, 1'b1);
        write(16'hF000, 8'h03, 1'b1);
        write(16'hFFFF, 8'h01, 1'b1);
        write(16'h7FFF, 8'h01, 1'b1);
        write(16'h4100, 8'h04, 1'b1);
        check_all("R9 outside");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_chr_nibbles();
        t_chr_alias();
        t_prg();
        t_mirror();
        t_mode();
        t_disabled();
        t_outside();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule